// File: doc/BRIEF.md
# Busy Timeout Monitor

This block watches the busy line of an engine and raises an error flag when the engine stays busy for too long. Time is measured in hang pulses, a slow periodic strobe supplied from outside. A programmable 5-bit divider can stretch the time base so that the count advances only once every n raw pulses. The counter measures time only while busy is high. When busy drops, both the counter and the divider phase return to zero.

The error flag rises when an increment makes the count equal to the programmed threshold. The flag then stays set until software writes a one to the clear input. The running count is available on an output so that the elapsed busy time can be observed.

Top module: `tmon_busy_watch`

## Requirements
- R1: While busy_i is high, count_o increases by exactly one in the cycle after each divided pulse. It does not change in any cycle without a divided pulse.
- R2: In the cycle after busy_i is seen low, count_o is 0. The divider phase also restarts, so the next divided pulse needs a full set of n raw pulses seen while busy.
- R3: err_o rises in the same cycle in which count_o first becomes equal to threshold_i through an increment. A threshold of 0 never raises err_o.
- R4: Once set, err_o stays high while counting continues past the threshold and after busy_i drops, until it is cleared.
- R5: When err_clr_i is 1 and no new match occurs, err_o is 0 in the next cycle. If a match and a clear happen in the same cycle, the match wins and err_o is 1.
- R6: Divider values 0 and 1 both pass every raw hang pulse. Each pulse seen while busy advances the count.
- R7: A divider value n from 2 to 31 produces one divided pulse for every n raw pulses seen while busy. The first divided pulse comes on the n-th raw pulse.
- R8: In divided mode with a threshold of 2, err_o rises on the second divided pulse, which is the 2n-th raw pulse.
- R9: count_o saturates at its all-ones value and does not wrap.
- R10: After reset, count_o is 0 and err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hang_pulse_i | input | 1 | Raw time-base strobe, one cycle wide |
| busy_i | input | 1 | Engine busy indication |
| threshold_i | input | CNT_W | Count value that flags a hang |
| div_sel_i | input | DIV_W | Pulse divider, 0 and 1 mean no division |
| err_clr_i | input | 1 | Write one to clear the error flag |
| err_o | output | 1 | Sticky hang error |
| count_o | output | CNT_W | Current busy-time count |

## Verification
A wrong divider phase appears at count_o one cycle after the raw pulse that should have produced the divided pulse, or that should not have. A counter that is stuck or skips a value shows up in the cycle after the pulse. A counter that fails to clear shows up in the first cycle after busy drops. A sticky flag that is lost, or a clear that loses priority to a match, changes err_o in the very next cycle. For these reasons the bench compares both outputs against a behavioural model on every clock, so any state error is reported at the first cycle in which it becomes visible.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
    localparam int unsigned TMON_DIV_W = 5;
    localparam int unsigned TMON_CNT_W = 16;

    // A divider setting below two leaves the raw pulse undivided.
    function automatic logic div_bypass(input logic [TMON_DIV_W-1:0] sel);
        return sel <= TMON_DIV_W'(1);
    endfunction
endpackage

// File: rtl/tmon_prescale.sv
module tmon_prescale
    import tmon_pkg::*;
#(
    parameter int unsigned DIV_W = TMON_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_i,
    input  logic             busy_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] phase;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       wrap;
    logic       bypass;

    always_comb begin
        st_d   = st_q;
        bypass = (div_i <= DIV_W'(1));
        wrap   = bypass || (st_q.phase >= DIV_W'(div_i - DIV_W'(1)));
        tick_o = pulse_i && busy_i && wrap;
        if (!busy_i) begin
            st_d.phase = '0;
        end else if (pulse_i) begin
            st_d.phase = wrap ? '0 : st_q.phase + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmon_count.sv
module tmon_count #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             busy_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             hit_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic             can_step;
    logic [CNT_W-1:0] next_val;

    always_comb begin
        st_d     = st_q;
        can_step = tick_i && busy_i && (st_q.cnt != CNT_MAX);
        next_val = st_q.cnt + CNT_W'(1);
        hit_o    = can_step && (next_val == thr_i);
        if (!busy_i) begin
            st_d.cnt = '0;
        end else if (can_step) begin
            st_d.cnt = next_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;
endmodule

// File: rtl/tmon_flag.sv
module tmon_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic err_o
);
    typedef struct packed {
        logic err;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i)      st_d.err = 1'b1;
        else if (clr_i) st_d.err = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_o = st_q.err;
endmodule

// File: rtl/tmon_busy_watch.sv
module tmon_busy_watch
    import tmon_pkg::*;
#(
    parameter int unsigned CNT_W = TMON_CNT_W,
    parameter int unsigned DIV_W = TMON_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hang_pulse_i,
    input  logic             busy_i,
    input  logic [CNT_W-1:0] threshold_i,
    input  logic [DIV_W-1:0] div_sel_i,
    input  logic             err_clr_i,
    output logic             err_o,
    output logic [CNT_W-1:0] count_o
);
    logic tick;
    logic hit;

    tmon_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (hang_pulse_i),
        .busy_i  (busy_i),
        .div_i   (div_sel_i),
        .tick_o  (tick)
    );

    tmon_count #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .busy_i  (busy_i),
        .thr_i   (threshold_i),
        .count_o (count_o),
        .hit_o   (hit)
    );

    tmon_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (hit),
        .clr_i (err_clr_i),
        .err_o (err_o)
    );
endmodule

// File: rtl/tmon_busy_watch_chk.sv
module tmon_busy_watch_chk #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned DIV_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hang_pulse_i,
    input logic             busy_i,
    input logic [CNT_W-1:0] threshold_i,
    input logic [DIV_W-1:0] div_sel_i,
    input logic             err_clr_i,
    input logic             err_o,
    input logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] FULL = '1;

    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |=> count_o == '0); // R2
    AST_HOLD_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !hang_pulse_i) |=> $stable(count_o)); // R1
    AST_RISE_AT_THR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> count_o == $past(threshold_i)); // R3
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !err_clr_i) |=> err_o); // R4
    AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr_i && !busy_i) |=> !err_o); // R5
    AST_BYPASS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && hang_pulse_i && div_sel_i <= DIV_W'(1) && count_o != FULL)
        |=> count_o == $past(count_o) + CNT_W'(1)); // R6
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && count_o == FULL) |=> count_o == FULL); // R9
endmodule

bind tmon_busy_watch tmon_busy_watch_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hang_pulse_i (hang_pulse_i),
    .busy_i       (busy_i),
    .threshold_i  (threshold_i),
    .div_sel_i    (div_sel_i),
    .err_clr_i    (err_clr_i),
    .err_o        (err_o),
    .count_o      (count_o)
);

// File: tb/tb_tmon_busy_watch.sv
module tb_tmon_busy_watch;
    localparam int CW = 6;
    localparam int DW = 5;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pulse = 1'b0;
    logic          busy = 1'b0;
    logic [CW-1:0] thr = '0;
    logic [DW-1:0] div = '0;
    logic          clr = 1'b0;
    logic          err;
    logic [CW-1:0] cnt;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    // behavioural reference state
    int m_phase = 0;
    int m_cnt = 0;
    bit m_err = 1'b0;

    always #2 clk = ~clk;

    tmon_busy_watch #(.CNT_W(CW), .DIV_W(DW)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hang_pulse_i (pulse),
        .busy_i       (busy),
        .threshold_i  (thr),
        .div_sel_i    (div),
        .err_clr_i    (clr),
        .err_o        (err),
        .count_o      (cnt)
    );

    always @(posedge clk) begin
        int n;
        bit wrap, tk, match;
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_err = 1'b0;
        end else begin
            n     = int'(div);
            wrap  = (n <= 1) || (m_phase >= n - 1);
            tk    = pulse && busy && wrap;
            match = tk && (m_cnt < CMAX) && (m_cnt + 1 == int'(thr));
            if (!busy) m_phase = 0;
            else if (pulse) m_phase = wrap ? 0 : m_phase + 1;
            if (!busy) m_cnt = 0;
            else if (tk && m_cnt < CMAX) m_cnt = m_cnt + 1;
            if (match) m_err = 1'b1;
            else if (clr) m_err = 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // one clock: drive at negedge, then compare with the model at the next negedge
    task automatic step(input bit p, input bit b, input bit c);
        pulse = p; busy = b; clr = c;
        @(negedge clk);
        check(int'(cnt) == m_cnt, "R1 count vs model", int'(cnt), m_cnt);
        check(err == m_err, "R3 err vs model", int'(err), int'(m_err));
    endtask

    task automatic pulses(input int k);
        for (int i = 0; i < k; i++) begin
            step(1, 1, 0);
            step(0, 1, 0);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cnt == 0, "R10 reset count", int'(cnt), 0);
        check(err == 0, "R10 reset err", int'(err), 0);

        // undivided, threshold 5
        div = 5'd0; thr = 6'd5;
        pulses(4);
        check(cnt == 4, "R6 div0 count", int'(cnt), 4);
        check(err == 0, "R3 below thr", int'(err), 0);
        step(1, 1, 0);
        check(err == 1 && cnt == 5, "R3 hit at thr", int'(err), 1);
        pulses(2);
        check(cnt == 7, "R4 count past thr", int'(cnt), 7);
        check(err == 1, "R4 sticky", int'(err), 1);
        step(1, 0, 0);
        check(cnt == 0, "R2 clear on idle", int'(cnt), 0);
        check(err == 1, "R4 sticky idle", int'(err), 1);
        step(0, 0, 1);
        check(err == 0, "R5 clear", int'(err), 0);

        // divider 1 behaves like 0
        div = 5'd1; thr = 6'd3;
        pulses(3);
        check(cnt == 3 && err == 1, "R6 div1 hit", int'(cnt), 3);
        step(0, 0, 1);

        // divide by 3, threshold 2
        div = 5'd3; thr = 6'd2;
        pulses(5);
        check(cnt == 1, "R7 div3 count", int'(cnt), 1);
        check(err == 0, "R8 not yet", int'(err), 0);
        step(1, 1, 0);
        check(cnt == 2 && err == 1, "R8 hit on 2nd divided", int'(err), 1);
        step(0, 0, 1);

        // phase restart after busy drop, divide by 4
        div = 5'd4; thr = 6'd0;
        pulses(3);
        step(0, 0, 0);
        pulses(3);
        check(cnt == 0, "R2 phase restart", int'(cnt), 0);
        step(1, 1, 0);
        check(cnt == 1, "R7 div4 first tick", int'(cnt), 1);
        step(0, 0, 0);

        // match and clear together: match wins
        div = 5'd0; thr = 6'd2;
        pulses(1);
        step(1, 1, 1);
        check(err == 1, "R5 set beats clear", int'(err), 1);
        step(0, 0, 1);
        check(err == 0, "R5 clear after", int'(err), 0);

        // threshold zero never flags, and saturation
        thr = 6'd0;
        pulses(70);
        check(cnt == CMAX, "R9 saturate", int'(cnt), CMAX);
        check(err == 0, "R3 thr0 silent", int'(err), 0);
        step(0, 0, 0);

        // divide by 31
        div = 5'd31;
        pulses(30);
        check(cnt == 0, "R7 div31 before", int'(cnt), 0);
        pulses(1);
        check(cnt == 1, "R7 div31 tick", int'(cnt), 1);
        step(0, 0, 0);

        finish_run();
    end
endmodule